// File: doc/BRIEF.md
# Security-Banked Binary Point Register Slice

This block is the register slice of an interrupt controller CPU interface that holds, for each CPU, the binary point setting in two copies: a primary copy and an alternate copy. The alternate copy is the one a non-secure agent sees when security support is built in. A register bus carries an address offset, a CPU index, a write enable, write data and a secure flag. The offset, the security of the access and two build options decide which copy a given access reaches. The build options are security support and interrupt grouping. The slice also keeps the per-CPU priority mask and four active-priority words. The controller logic reads these values; prioritisation itself is not part of this block.

Each access takes one cycle. A write takes effect at the clock edge. The read data for the presented offset is registered at the same edge, so it shows the contents from before any write in that cycle. A binary point write keeps only bits [2:0] of the data and is raised to the minimum of the copy it reaches.

Top module: `cpu_bpr_bank`

## Requirements
- R1: After reset, each CPU's primary binary point holds BPR_MIN (0) and its alternate holds ABPR_MIN (1). The priority mask and all active-priority words are zero, and rd_data is zero.
- R2: rd_data in the cycle after an access shows the addressed register's contents from before any write made by that access.
- R3: Offset 0x08 reaches the primary copy when the access is secure or security support is absent. A write stores wdata[2:0], and a read returns that value zero-extended.
- R4: With security support, a non-secure access to offset 0x08 reaches the alternate copy, and the primary copy is left alone.
- R5: With grouping, a secure access to offset 0x1c reaches the alternate copy.
- R6: With security support, a non-secure access to offset 0x1c reads zero and its write changes nothing.
- R7: A binary point write stores max(wdata[2:0], minimum of the copy written): 0 for the primary copy and 1 for the alternate copy.
- R8: Offset 0x04 holds the 8-bit priority mask. A write keeps wdata[7:0], and a read returns it zero-extended, whatever the secure flag.
- R9: Offsets 0xd0, 0xd4, 0xd8 and 0xdc hold active-priority words 0 to 3, each 32 bits wide and written independently.
- R10: Every register exists once per CPU. An access uses the copy of the CPU named by cpu_idx, and a write leaves all other CPUs unchanged.
- R11: Any other offset, including unaligned offsets inside 0xd0 to 0xdf, reads zero and its write changes nothing.
- R12: Without grouping and without security support, offset 0x1c reads zero and ignores writes. Offset 0x08 reaches the primary copy whatever the secure flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the presented access |
| addr | input | ADDR_W | Register offset |
| cpu_idx | input | CPU_W | CPU interface selected by the access |
| secure | input | 1 | 1 for a secure access, 0 for a non-secure access |
| wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data for the previous cycle's access |

## Verification
A write and the read of the same register fall in the same cycle, because every access also produces read data. The bench provokes this by making each table write also sample rd_data one cycle later, and by alternating secure writes to 0x1c with non-secure reads of 0x08 that reach the same storage. It judges a pass when the sampled value is the pre-write contents and the next read returns the clamped new value. A second instance built without grouping or security support receives the same offsets, so both decode variants can be compared.

// File: rtl/cpu_bpr_pkg.sv
package cpu_bpr_pkg;

  localparam int BP_W      = 3;
  localparam int PMR_W     = 8;
  localparam int APR_WORDS = 4;
  localparam int APR_SEL_W = $clog2(APR_WORDS);

  localparam logic [7:0] OFS_PMR  = 8'h04;
  localparam logic [7:0] OFS_BPR  = 8'h08;
  localparam logic [7:0] OFS_ALT  = 8'h1c;
  localparam logic [7:0] OFS_APR0 = 8'hd0;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PMR,
    TGT_BP_PRI,
    TGT_BP_ALT,
    TGT_APR
  } tgt_e;

  function automatic logic [BP_W-1:0] bp_floor(input logic [BP_W-1:0] val,
                                               input logic [BP_W-1:0] floor_v);
    return (val < floor_v) ? floor_v : val;
  endfunction

endpackage

// File: rtl/cpu_bpr_decode.sv
module cpu_bpr_decode #(
  parameter int ADDR_W     = 8,
  parameter bit SEC_EXT    = 1'b1,
  parameter bit HAS_GROUPS = 1'b1
) (
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               secure,
  output cpu_bpr_pkg::tgt_e                  tgt,
  output logic [cpu_bpr_pkg::APR_SEL_W-1:0]  apr_sel
);

  localparam logic [ADDR_W-1:0] A_PMR  = ADDR_W'(cpu_bpr_pkg::OFS_PMR);
  localparam logic [ADDR_W-1:0] A_BPR  = ADDR_W'(cpu_bpr_pkg::OFS_BPR);
  localparam logic [ADDR_W-1:0] A_ALT  = ADDR_W'(cpu_bpr_pkg::OFS_ALT);
  localparam logic [ADDR_W-1:0] A_APR0 = ADDR_W'(cpu_bpr_pkg::OFS_APR0);
  localparam logic [ADDR_W-1:0] A_APRL = ADDR_W'(cpu_bpr_pkg::OFS_APR0
                                         + 8'(4 * (cpu_bpr_pkg::APR_WORDS - 1)));

  logic ns_banked;
  logic alt_raz;
  logic in_apr;

  always_comb begin
    ns_banked = SEC_EXT && !secure;
    alt_raz   = !HAS_GROUPS || ns_banked;
    in_apr    = (addr >= A_APR0) && (addr <= A_APRL) && (addr[1:0] == 2'b00);
    apr_sel   = addr[2 +: cpu_bpr_pkg::APR_SEL_W];
    tgt       = cpu_bpr_pkg::TGT_NONE;
    if (addr == A_PMR) begin
      tgt = cpu_bpr_pkg::TGT_PMR;
    end else if (addr == A_BPR) begin
      tgt = ns_banked ? cpu_bpr_pkg::TGT_BP_ALT : cpu_bpr_pkg::TGT_BP_PRI;
    end else if (addr == A_ALT) begin
      tgt = alt_raz ? cpu_bpr_pkg::TGT_NONE : cpu_bpr_pkg::TGT_BP_ALT;
    end else if (in_apr) begin
      tgt = cpu_bpr_pkg::TGT_APR;
    end
  end

endmodule

// File: rtl/cpu_bpr_slice.sv
module cpu_bpr_slice #(
  parameter int DATA_W   = 32,
  parameter int BPR_MIN  = 0,
  parameter int ABPR_MIN = 1
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                wr_hit,
  input  cpu_bpr_pkg::tgt_e                                   tgt,
  input  logic [cpu_bpr_pkg::APR_SEL_W-1:0]                   apr_sel,
  input  logic [DATA_W-1:0]                                   wdata,
  output logic [cpu_bpr_pkg::BP_W-1:0]                        bp_pri_q,
  output logic [cpu_bpr_pkg::BP_W-1:0]                        bp_alt_q,
  output logic [cpu_bpr_pkg::PMR_W-1:0]                       pmr_q,
  output logic [cpu_bpr_pkg::APR_WORDS-1:0][DATA_W-1:0]       apr_q
);

  localparam int BW = cpu_bpr_pkg::BP_W;
  localparam logic [BW-1:0] PRI_FLOOR = BW'(BPR_MIN);
  localparam logic [BW-1:0] ALT_FLOOR = BW'(ABPR_MIN);

  logic                bp_pri_en, bp_alt_en, pmr_en;
  logic [BW-1:0]       bp_pri_d, bp_alt_d;
  logic [cpu_bpr_pkg::PMR_W-1:0] pmr_d;
  logic [cpu_bpr_pkg::APR_WORDS-1:0] apr_en;

  always_comb begin
    bp_pri_en = wr_hit && (tgt == cpu_bpr_pkg::TGT_BP_PRI);
    bp_alt_en = wr_hit && (tgt == cpu_bpr_pkg::TGT_BP_ALT);
    pmr_en    = wr_hit && (tgt == cpu_bpr_pkg::TGT_PMR);
    bp_pri_d  = cpu_bpr_pkg::bp_floor(wdata[BW-1:0], PRI_FLOOR);
    bp_alt_d  = cpu_bpr_pkg::bp_floor(wdata[BW-1:0], ALT_FLOOR);
    pmr_d     = wdata[cpu_bpr_pkg::PMR_W-1:0];
    for (int w = 0; w < cpu_bpr_pkg::APR_WORDS; w++) begin
      apr_en[w] = wr_hit && (tgt == cpu_bpr_pkg::TGT_APR)
                  && (apr_sel == cpu_bpr_pkg::APR_SEL_W'(w));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_pri_q <= PRI_FLOOR;
      bp_alt_q <= ALT_FLOOR;
      pmr_q    <= '0;
    end else begin
      if (bp_pri_en) bp_pri_q <= bp_pri_d;
      if (bp_alt_en) bp_alt_q <= bp_alt_d;
      if (pmr_en)    pmr_q    <= pmr_d;
    end
  end

  for (genvar w = 0; w < cpu_bpr_pkg::APR_WORDS; w++) begin : g_apr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        apr_q[w] <= '0;
      end else if (apr_en[w]) begin
        apr_q[w] <= wdata;
      end
    end
  end

endmodule

// File: rtl/cpu_bpr_rdsel.sv
module cpu_bpr_rdsel #(
  parameter int DATA_W = 32
) (
  input  cpu_bpr_pkg::tgt_e                              tgt,
  input  logic [cpu_bpr_pkg::APR_SEL_W-1:0]              apr_sel,
  input  logic                                           cpu_ok,
  input  logic [cpu_bpr_pkg::BP_W-1:0]                   bp_pri,
  input  logic [cpu_bpr_pkg::BP_W-1:0]                   bp_alt,
  input  logic [cpu_bpr_pkg::PMR_W-1:0]                  pmr,
  input  logic [cpu_bpr_pkg::APR_WORDS-1:0][DATA_W-1:0]  apr,
  output logic [DATA_W-1:0]                              rd_d
);

  always_comb begin
    rd_d = '0;
    if (cpu_ok) begin
      unique case (tgt)
        cpu_bpr_pkg::TGT_PMR:    rd_d = DATA_W'(pmr);
        cpu_bpr_pkg::TGT_BP_PRI: rd_d = DATA_W'(bp_pri);
        cpu_bpr_pkg::TGT_BP_ALT: rd_d = DATA_W'(bp_alt);
        cpu_bpr_pkg::TGT_APR:    rd_d = apr[apr_sel];
        default:                 rd_d = '0;
      endcase
    end
  end

endmodule

// File: rtl/cpu_bpr_bank.sv
module cpu_bpr_bank #(
  parameter int NUM_CPU    = 2,
  parameter int CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter bit SEC_EXT    = 1'b1,
  parameter bit HAS_GROUPS = 1'b1,
  parameter int BPR_MIN    = 0,
  parameter int ABPR_MIN   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CPU_W-1:0]  cpu_idx,
  input  logic              secure,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);

  localparam int BW  = cpu_bpr_pkg::BP_W;
  localparam int PW  = cpu_bpr_pkg::PMR_W;
  localparam int NW  = cpu_bpr_pkg::APR_WORDS;
  localparam int SW  = cpu_bpr_pkg::APR_SEL_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cpu_bpr_pkg::tgt_e tgt;
  logic [SW-1:0]     apr_sel;

  cpu_bpr_decode #(
    .ADDR_W     (ADDR_W),
    .SEC_EXT    (SEC_EXT),
    .HAS_GROUPS (HAS_GROUPS)
  ) u_decode (
    .addr    (addr),
    .secure  (secure),
    .tgt     (tgt),
    .apr_sel (apr_sel)
  );

  logic [NUM_CPU-1:0][BW-1:0]         bpr_all;
  logic [NUM_CPU-1:0][BW-1:0]         abpr_all;
  logic [NUM_CPU-1:0][PW-1:0]         pmr_all;
  logic [NUM_CPU-1:0][NW-1:0][DATA_W-1:0] apr_all;
  logic [NUM_CPU-1:0]                 wr_hit;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign wr_hit[c] = wr_en && (cpu_idx == CPU_W'(c));

    cpu_bpr_slice #(
      .DATA_W   (DATA_W),
      .BPR_MIN  (BPR_MIN),
      .ABPR_MIN (ABPR_MIN)
    ) u_slice (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_hit   (wr_hit[c]),
      .tgt      (tgt),
      .apr_sel  (apr_sel),
      .wdata    (wdata),
      .bp_pri_q (bpr_all[c]),
      .bp_alt_q (abpr_all[c]),
      .pmr_q    (pmr_all[c]),
      .apr_q    (apr_all[c])
    );
  end

  logic                          cpu_ok;
  logic [BW-1:0]                 sel_pri, sel_alt;
  logic [PW-1:0]                 sel_pmr;
  logic [NW-1:0][DATA_W-1:0]     sel_apr;

  always_comb begin
    cpu_ok  = 1'b0;
    sel_pri = '0;
    sel_alt = '0;
    sel_pmr = '0;
    sel_apr = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpu_idx == CPU_W'(c)) begin
        cpu_ok  = 1'b1;
        sel_pri = bpr_all[c];
        sel_alt = abpr_all[c];
        sel_pmr = pmr_all[c];
        sel_apr = apr_all[c];
      end
    end
  end

  logic [DATA_W-1:0] rd_d;

  cpu_bpr_rdsel #(
    .DATA_W (DATA_W)
  ) u_rdsel (
    .tgt     (tgt),
    .apr_sel (apr_sel),
    .cpu_ok  (cpu_ok),
    .bp_pri  (sel_pri),
    .bp_alt  (sel_alt),
    .pmr     (sel_pmr),
    .apr     (sel_apr),
    .rd_d    (rd_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_data <= '0;
    else             rd_data <= rd_d;
  end

endmodule

// File: rtl/cpu_bpr_bank_chk.sv
module cpu_bpr_bank_chk #(
  parameter int NUM_CPU    = 2,
  parameter int CPU_W      = 1,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter bit SEC_EXT    = 1'b1,
  parameter bit HAS_GROUPS = 1'b1,
  parameter int BPR_MIN    = 0,
  parameter int ABPR_MIN   = 1
) (
  input logic                                                   clk,
  input logic                                                   rst_n,
  input logic                                                   wr_en,
  input logic [ADDR_W-1:0]                                      addr,
  input logic [CPU_W-1:0]                                       cpu_idx,
  input logic                                                   secure,
  input logic [DATA_W-1:0]                                      wdata,
  input logic [DATA_W-1:0]                                      rd_data,
  input logic [NUM_CPU-1:0][cpu_bpr_pkg::BP_W-1:0]              bpr_all,
  input logic [NUM_CPU-1:0][cpu_bpr_pkg::BP_W-1:0]              abpr_all,
  input logic [NUM_CPU-1:0][cpu_bpr_pkg::PMR_W-1:0]             pmr_all,
  input logic [NUM_CPU-1:0][cpu_bpr_pkg::APR_WORDS-1:0][DATA_W-1:0] apr_all
);

  logic at_bpr, at_alt, at_pmr, alt_blocked;
  always_comb begin
    at_bpr      = (addr == ADDR_W'(8'h08));
    at_alt      = (addr == ADDR_W'(8'h1c));
    at_pmr      = (addr == ADDR_W'(8'h04));
    alt_blocked = !HAS_GROUPS || (SEC_EXT && !secure);
  end

  // R6 / R12: blocked alias offset reads zero
  p_alias_raz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_alt && alt_blocked) |=> (rd_data == '0));

  // R6 / R12: blocked alias write changes no binary point copy
  p_alias_wi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_alt && alt_blocked) |=> ($stable(abpr_all) && $stable(bpr_all)));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    // R7: stored copies never fall below their minimums
    p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bpr_all[c]) >= BPR_MIN) && (int'(abpr_all[c]) >= ABPR_MIN));

    // R3: primary copy read through 0x08
    p_pri_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (at_bpr && (secure || !SEC_EXT) && cpu_idx == CPU_W'(c))
      |=> (rd_data == DATA_W'($past(bpr_all[c]))));

    // R4: non-secure 0x08 reaches the alternate copy
    p_alt_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (at_bpr && SEC_EXT && !secure && cpu_idx == CPU_W'(c))
      |=> (rd_data == DATA_W'($past(abpr_all[c]))));

    // R5: permitted 0x1c reaches the alternate copy
    p_alias_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (at_alt && !alt_blocked && cpu_idx == CPU_W'(c))
      |=> (rd_data == DATA_W'($past(abpr_all[c]))));

    // R8: priority mask keeps the low byte of the write
    p_pmr_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && at_pmr && cpu_idx == CPU_W'(c))
      |=> (pmr_all[c] == $past(wdata[cpu_bpr_pkg::PMR_W-1:0])));

    // R10: writes for another CPU leave this one untouched
    p_other_cpu_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cpu_idx != CPU_W'(c))
      |=> ($stable(bpr_all[c]) && $stable(abpr_all[c])
           && $stable(pmr_all[c]) && $stable(apr_all[c])));
  end

endmodule

bind cpu_bpr_bank cpu_bpr_bank_chk #(
  .NUM_CPU    (NUM_CPU),
  .CPU_W      (CPU_W),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .SEC_EXT    (SEC_EXT),
  .HAS_GROUPS (HAS_GROUPS),
  .BPR_MIN    (BPR_MIN),
  .ABPR_MIN   (ABPR_MIN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .cpu_idx  (cpu_idx),
  .secure   (secure),
  .wdata    (wdata),
  .rd_data  (rd_data),
  .bpr_all  (bpr_all),
  .abpr_all (abpr_all),
  .pmr_all  (pmr_all),
  .apr_all  (apr_all)
);

// File: tb/cpu_bpr_bank_tb.sv
module cpu_bpr_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr, wr_b, cpu, sec;
  logic [7:0]  addr;
  logic [31:0] wd;
  logic [31:0] rd_a, rd_b;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cpu_bpr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .addr(addr), .cpu_idx(cpu),
    .secure(sec), .wdata(wd), .rd_data(rd_a)
  );

  cpu_bpr_bank #(.SEC_EXT(1'b0), .HAS_GROUPS(1'b0)) u_dut_ng (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .addr(addr), .cpu_idx(cpu),
    .secure(sec), .wdata(wd), .rd_data(rd_b)
  );

  typedef struct packed {
    logic        w;
    logic [7:0]  a;
    logic        c;
    logic        s;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TAB [0:NV-1] = '{
    '{1'b0, 8'h08, 1'b0, 1'b1, 32'h0,        32'h0,        8'd1},  // R1 primary at min
    '{1'b0, 8'h08, 1'b0, 1'b0, 32'h0,        32'h1,        8'd1},  // R1 alternate at min
    '{1'b0, 8'h1c, 1'b0, 1'b1, 32'h0,        32'h1,        8'd5},  // R5
    '{1'b1, 8'h08, 1'b0, 1'b1, 32'hFFFFFFF5, 32'h0,        8'd2},  // R2 old value
    '{1'b0, 8'h08, 1'b0, 1'b1, 32'h0,        32'h5,        8'd3},  // R3 low bits
    '{1'b0, 8'h08, 1'b0, 1'b0, 32'h0,        32'h1,        8'd4},  // R4 alt untouched
    '{1'b1, 8'h08, 1'b0, 1'b0, 32'h6,        32'h1,        8'd4},  // R4 write alt
    '{1'b0, 8'h1c, 1'b0, 1'b1, 32'h0,        32'h6,        8'd5},  // R5 alias sees it
    '{1'b0, 8'h08, 1'b0, 1'b1, 32'h0,        32'h5,        8'd4},  // R4 primary kept
    '{1'b1, 8'h1c, 1'b0, 1'b1, 32'h0,        32'h6,        8'd2},  // R2
    '{1'b0, 8'h08, 1'b0, 1'b0, 32'h0,        32'h1,        8'd7},  // R7 alt floor
    '{1'b1, 8'h1c, 1'b0, 1'b0, 32'h3,        32'h0,        8'd6},  // R6 raz
    '{1'b0, 8'h1c, 1'b0, 1'b1, 32'h0,        32'h1,        8'd6},  // R6 write ignored
    '{1'b1, 8'h08, 1'b0, 1'b1, 32'h0,        32'h5,        8'd2},  // R2
    '{1'b0, 8'h08, 1'b0, 1'b1, 32'h0,        32'h0,        8'd7},  // R7 primary floor 0
    '{1'b1, 8'h04, 1'b1, 1'b1, 32'h000001A5, 32'h0,        8'd8},  // R8
    '{1'b0, 8'h04, 1'b1, 1'b0, 32'h0,        32'hA5,       8'd8},  // R8 byte kept
    '{1'b0, 8'h04, 1'b0, 1'b1, 32'h0,        32'h0,        8'd10}, // R10
    '{1'b1, 8'hd0, 1'b1, 1'b1, 32'h11111111, 32'h0,        8'd9},  // R9
    '{1'b1, 8'hdc, 1'b1, 1'b0, 32'hDEADBEEF, 32'h0,        8'd9},  // R9
    '{1'b0, 8'hd0, 1'b1, 1'b1, 32'h0,        32'h11111111, 8'd9},  // R9
    '{1'b0, 8'hd4, 1'b1, 1'b1, 32'h0,        32'h0,        8'd9},  // R9
    '{1'b0, 8'hdc, 1'b1, 1'b1, 32'h0,        32'hDEADBEEF, 8'd9},  // R9
    '{1'b0, 8'hdc, 1'b0, 1'b1, 32'h0,        32'h0,        8'd10}, // R10
    '{1'b1, 8'h08, 1'b1, 1'b0, 32'h4,        32'h1,        8'd10}, // R10
    '{1'b0, 8'h08, 1'b0, 1'b0, 32'h0,        32'h1,        8'd10}, // R10 cpu0 kept
    '{1'b0, 8'h1c, 1'b1, 1'b1, 32'h0,        32'h4,        8'd10}, // R10 cpu1 got it
    '{1'b1, 8'h40, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h0,        8'd11}, // R11
    '{1'b0, 8'h40, 1'b0, 1'b1, 32'h0,        32'h0,        8'd11}, // R11
    '{1'b1, 8'hd2, 1'b1, 1'b1, 32'h0,        32'h0,        8'd11}, // R11 unaligned
    '{1'b0, 8'hd0, 1'b1, 1'b1, 32'h0,        32'h11111111, 8'd11}  // R11 no effect
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with read data.
  task automatic acc(input logic w, input logic wb, input logic [7:0] a,
                     input logic c, input logic s, input logic [31:0] d);
    wr = w; wr_b = wb; addr = a; cpu = c; sec = s; wd = d;
    @(negedge clk);
    wr = 1'b0; wr_b = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(1, "rd_data in reset", rd_a, 32'h0);  // R1
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr = 1'b0; wr_b = 1'b0; cpu = 1'b0; sec = 1'b1;
    addr = 8'h0; wd = 32'h0;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      acc(TAB[i].w, 1'b0, TAB[i].a, TAB[i].c, TAB[i].s, TAB[i].d);
      check(int'(TAB[i].req), $sformatf("vector %0d", i), rd_a, TAB[i].e);
    end

    // R2: secure write to the alias and the same register read in one cycle
    acc(1'b1, 1'b0, 8'h1c, 1'b1, 1'b1, 32'h7);
    check(2, "same-cycle read shows old alt", rd_a, 32'h4);
    acc(1'b0, 1'b0, 8'h08, 1'b1, 1'b0, 32'h0);
    check(2, "alt after write via 0x08 ns", rd_a, 32'h7);

    // R12: build without grouping or security support
    acc(1'b0, 1'b1, 8'h08, 1'b0, 1'b0, 32'h3);
    check(12, "ng 0x08 old primary", rd_b, 32'h0);
    acc(1'b0, 1'b0, 8'h08, 1'b0, 1'b1, 32'h0);
    check(12, "ng secure 0x08 sees ns write", rd_b, 32'h3);
    acc(1'b0, 1'b1, 8'h1c, 1'b0, 1'b1, 32'h5);
    check(12, "ng 0x1c raz", rd_b, 32'h0);
    acc(1'b0, 1'b0, 8'h1c, 1'b0, 1'b1, 32'h0);
    check(12, "ng 0x1c still zero", rd_b, 32'h0);
    acc(1'b0, 1'b0, 8'h08, 1'b0, 1'b0, 32'h0);
    check(12, "ng primary unchanged", rd_b, 32'h3);

    // R1: reset in mid-run restores minimums and clears words
    do_reset();
    acc(1'b0, 1'b0, 8'h08, 1'b1, 1'b0, 32'h0);
    check(1, "alt back to min", rd_a, 32'h1);
    acc(1'b0, 1'b0, 8'h04, 1'b1, 1'b1, 32'h0);
    check(1, "pmr cleared", rd_a, 32'h0);
    acc(1'b0, 1'b0, 8'hdc, 1'b1, 1'b1, 32'h0);
    check(1, "apr cleared", rd_a, 32'h0);
    acc(1'b0, 1'b0, 8'h08, 1'b0, 1'b0, 32'h0);
    check(1, "ng primary back to min", rd_b, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule